// File: doc/BRIEF.md
# TDM Telephony Serial Port (PCM / IOM-2)

This block carries 8-bit channel data between a time-division multiplexed serial line and a parallel side. Each frame holds twelve slots of eight bits each, sent MSB first. The line has four wires: bit clock, frame sync, transmit data and receive data. As master, the port divides its system clock down to make the bit clock and the frame sync. As slave, it takes both from the pins and locks onto the frame sync.

There are three line formats. Plain PCM carries one data bit per bit-clock period. IOM-2 uses double clocking, with two bit-clock periods per data bit. Multi-protocol PCM keeps single clocking, but each slot is set to either transmit or receive. Every slot has its own enable. Software or DMA loads a transmit byte for each slot and reads a received byte for each slot. At every frame boundary the port raises request lines for both DMA directions and a maskable frame interrupt. It also keeps sticky flags for transmit underrun and receive overrun.

Top module: `tdm_serial_port`

## Requirements
- R1: A frame is 12 slots of 8 bits, sent MSB first, starting at slot 0. In master mode `fsync_o` is high for exactly the first data bit of slot 0 and low for the other 95 data bits of the frame.
- R2: In master mode, while `run` is high, `bclk_o` toggles every HALF_DIV system clocks (default 4).
- R3: Format code `fmt` selects the line format: 0 = PCM, 1 = multi-protocol PCM, 2 = IOM-2, 3 = PCM. In PCM one bit-clock period carries one bit. In IOM-2 a bit spans two periods. Transmit bits change after a rising bit-clock edge. Receive bits are sampled at the falling edge that ends the bit.
- R4: Slot n is active only when `slot_en[n]` is 1. In an inactive slot `txd_oe` is 0 and nothing is stored from the line.
- R5: With `fmt`=1, `slot_dir[n]`=1 makes slot n transmit only (`txd_oe` high) and 0 makes it receive only (`txd_oe` low). In the other formats an enabled slot both transmits and receives.
- R6: In slave mode `bclk_in` and `fsync_in` clock the line. A rise of `fsync_in`, seen at a falling bit-clock edge, realigns the port to slot 0 bit 0, so the port synchronises to an arbitrary start phase within one frame.
- R7: At each frame boundary, `tx_dma_req` sets if any slot transmits and `rx_dma_req` sets if any slot receives. Each stays high until its `*_dma_clr` input is pulsed.
- R8: At each frame boundary `irq` sets unless `irq_mask` is 1. It stays high until `irq_clr` is pulsed.
- R9: `tx_underrun` sets when a transmit slot starts and its byte has not been rewritten since that slot last started. `rx_overrun` sets when a byte is stored into a slot that has not been read (`rx_rd`) since its last store. Both flags are sticky and clear on `irq_clr`.
- R10: While `run` is low, `bclk_o`, `fsync_o` and `txd_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the line engine |
| master | input | 1 | 1 = generate clocks, 0 = take clocks from pins |
| fmt | input | 2 | Line format code |
| slot_en | input | 12 | Per-slot enable |
| slot_dir | input | 12 | Per-slot direction in multi-protocol mode (1 = transmit) |
| irq_mask | input | 1 | Blocks the frame interrupt |
| irq_clr | input | 1 | Clears irq and the error flags |
| tx_wr | input | 1 | Write strobe for a transmit slot byte |
| tx_wr_slot | input | 4 | Slot written by tx_wr |
| tx_wr_data | input | 8 | Byte written by tx_wr |
| rx_rd | input | 1 | Marks a received slot byte as read |
| rx_rd_slot | input | 4 | Slot selected for reading |
| rx_rd_data | output | 8 | Received byte of rx_rd_slot |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_dma_clr | input | 1 | Clears tx_dma_req |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_dma_clr | input | 1 | Clears rx_dma_req |
| irq | output | 1 | Frame interrupt |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_overrun | output | 1 | Sticky receive overrun |
| bclk_in | input | 1 | Bit clock from the line (slave) |
| fsync_in | input | 1 | Frame sync from the line (slave) |
| rxd | input | 1 | Receive data |
| bclk_o | output | 1 | Bit clock driven in master mode |
| fsync_o | output | 1 | Frame sync driven in master mode |
| txd | output | 1 | Transmit data |
| txd_oe | output | 1 | Transmit output enable |

## Verification
The assertions take for granted that `master`, `fmt`, `slot_en` and `slot_dir` change only while `run` is low. The bit-clock and frame-sync checks depend on that: a mode change in mid-frame could stop `bclk_o` early or move the frame sync off a rising edge. The stimulus follows this rule by choosing a fresh random configuration only between runs, with the engine stopped. In slave mode the line clock stays slow, at eight system clocks per phase, so that the synchronised edges and data settle well inside each phase. Slave runs also begin with several idle bit periods before the first frame sync, to exercise realignment.

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int SLOTS    = 12,
  parameter int SLOT_W   = 8,
  parameter int HALF_DIV = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(SLOT_W),
  localparam int CW = $clog2(HALF_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              master,
  input  logic [1:0]        fmt,
  input  logic [SLOTS-1:0]  slot_en,
  input  logic [SLOTS-1:0]  slot_dir,
  input  logic              irq_mask,
  input  logic              irq_clr,
  input  logic              tx_wr,
  input  logic [SW-1:0]     tx_wr_slot,
  input  logic [SLOT_W-1:0] tx_wr_data,
  input  logic              rx_rd,
  input  logic [SW-1:0]     rx_rd_slot,
  output logic [SLOT_W-1:0] rx_rd_data,
  output logic              tx_dma_req,
  input  logic              tx_dma_clr,
  output logic              rx_dma_req,
  input  logic              rx_dma_clr,
  output logic              irq,
  output logic              tx_underrun,
  output logic              rx_overrun,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              rxd,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              txd,
  output logic              txd_oe
);
  localparam logic [1:0] FMT_MP  = 2'd1;
  localparam logic [1:0] FMT_IOM = 2'd2;

  logic [SLOT_W-1:0] tx_buf [SLOTS];
  logic [SLOT_W-1:0] rx_buf [SLOTS];
  logic [SLOTS-1:0]  tx_full, rx_full, tx_act, rx_act;
  logic [CW-1:0]     div_q;
  logic [2:0]        bclk_s;
  logic [1:0]        fsync_s, rxd_s;
  logic              fs_prev, live, cyc_q, cyc_n;
  logic [SW-1:0]     slot_q, slot_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic [SLOT_W-2:0] rx_sh;

  wire dbl       = fmt == FMT_IOM;
  assign tx_act  = slot_en & ((fmt == FMT_MP) ? slot_dir : '1);
  assign rx_act  = slot_en & ((fmt == FMT_MP) ? ~slot_dir : '1);
  wire div_wrap  = div_q == CW'(HALF_DIV - 1);
  wire rise_ev   = run & (master ? (div_wrap & ~bclk_o) : (bclk_s[1] & ~bclk_s[2]));
  wire fall_ev   = run & (master ? (div_wrap & bclk_o) : (~bclk_s[1] & bclk_s[2]));
  wire last_cyc  = ~dbl | cyc_q;
  wire last_bit  = bit_q == BW'(SLOT_W - 1);
  wire last_slot = slot_q == SW'(SLOTS - 1);
  wire frame_ev  = rise_ev & last_cyc & last_bit & last_slot;
  wire lock      = ~master & fall_ev & fsync_s[1] & ~fs_prev;
  wire rx_take   = fall_ev & live & last_cyc & rx_act[slot_q];
  wire rx_store  = rx_take & last_bit;
  wire [SLOT_W-1:0] rx_byte = {rx_sh, rxd_s[1]};
  wire slot_go   = rise_ev & ~cyc_n & (bit_n == '0) & tx_act[slot_n];

  always_comb begin
    slot_n = slot_q;
    bit_n  = bit_q;
    cyc_n  = 1'b1;
    if (last_cyc) begin
      cyc_n = 1'b0;
      bit_n = last_bit ? '0 : bit_q + 1'b1;
      if (last_bit) slot_n = last_slot ? '0 : slot_q + 1'b1;
    end
  end

  assign txd        = tx_buf[slot_q][BW'(SLOT_W - 1) - bit_q];
  assign txd_oe     = run & live & tx_act[slot_q];
  assign fsync_o    = run & master & live & (slot_q == '0) & (bit_q == '0);
  assign rx_rd_data = rx_buf[rx_rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      bclk_o  <= 1'b0;
      bclk_s  <= '0;
      fsync_s <= '0;
      rxd_s   <= '0;
      fs_prev <= 1'b0;
      live    <= 1'b0;
      slot_q  <= SW'(SLOTS - 1);
      bit_q   <= BW'(SLOT_W - 1);
      cyc_q   <= 1'b1;
      rx_sh   <= '0;
    end else begin
      bclk_s  <= {bclk_s[1:0], bclk_in};
      fsync_s <= {fsync_s[0], fsync_in};
      rxd_s   <= {rxd_s[0], rxd};
      if (!run || !master) begin
        div_q  <= '0;
        bclk_o <= 1'b0;
      end else if (div_wrap) begin
        div_q  <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        div_q  <= div_q + 1'b1;
      end
      if (!run)         fs_prev <= 1'b0;
      else if (fall_ev) fs_prev <= fsync_s[1];
      if (!run) begin
        live   <= 1'b0;
        slot_q <= SW'(SLOTS - 1);
        bit_q  <= BW'(SLOT_W - 1);
        cyc_q  <= 1'b1;
      end else if (lock) begin
        live   <= 1'b1;
        slot_q <= '0;
        bit_q  <= '0;
        cyc_q  <= 1'b0;
      end else if (rise_ev) begin
        live   <= 1'b1;
        slot_q <= slot_n;
        bit_q  <= bit_n;
        cyc_q  <= cyc_n;
      end
      if (rx_take) rx_sh <= rx_byte[SLOT_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr)    tx_buf[tx_wr_slot] <= tx_wr_data;
    if (rx_store) rx_buf[slot_q]     <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full     <= '0;
      rx_full     <= '0;
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
      irq         <= 1'b0;
      tx_dma_req  <= 1'b0;
      rx_dma_req  <= 1'b0;
    end else begin
      if (irq_clr) begin
        tx_underrun <= 1'b0;
        rx_overrun  <= 1'b0;
        irq         <= 1'b0;
      end
      if (slot_go) begin
        tx_full[slot_n] <= 1'b0;
        if (!tx_full[slot_n]) tx_underrun <= 1'b1;
      end
      if (tx_wr) tx_full[tx_wr_slot] <= 1'b1;
      if (rx_rd) rx_full[rx_rd_slot] <= 1'b0;
      if (rx_store) begin
        rx_full[slot_q] <= 1'b1;
        if (rx_full[slot_q]) rx_overrun <= 1'b1;
      end
      if (frame_ev && !irq_mask) irq <= 1'b1;
      if (tx_dma_clr) tx_dma_req <= 1'b0;
      if (frame_ev && |tx_act) tx_dma_req <= 1'b1;
      if (rx_dma_clr) rx_dma_req <= 1'b0;
      if (frame_ev && |rx_act) rx_dma_req <= 1'b1;
    end
  end

  assert_bclk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && master && !div_wrap) |=> $stable(bclk_o));
  assert_fsync_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $rose(fsync_o)) |-> $rose(bclk_o));
  assert_txreq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req && !tx_dma_clr) |=> tx_dma_req);
  assert_rxreq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_req && !rx_dma_clr) |=> rx_dma_req);
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask && !irq) |=> !irq);
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun && !irq_clr) |=> tx_underrun);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !irq_clr) |=> rx_overrun);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk_o && !txd_oe));
endmodule

// File: tb/tdm_serial_port_tb.sv
`timescale 1ns/1ps
module tdm_serial_port_tb;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, run = 0, master = 0;
  logic [1:0] fmt = 0;
  logic [11:0] slot_en = 0, slot_dir = 0;
  logic irq_mask = 0, irq_clr = 0, tx_wr = 0, rx_rd = 0;
  logic [3:0] tx_wr_slot = 0, rx_rd_slot = 0;
  logic [7:0] tx_wr_data = 0, rx_rd_data;
  logic tx_dma_req, tx_dma_clr = 0, rx_dma_req, rx_dma_clr = 0;
  logic irq, tx_underrun, rx_overrun;
  logic bclk_in = 0, fsync_in = 0, rxd = 0, bclk_o, fsync_o, txd, txd_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_tx [12];
  logic [7:0] rxpat [12];
  logic [7:0] cap = 0;
  int p = 0, frame_no = 0, mult = 1;
  bit synced = 0;

  always #2.5 clk = ~clk;

  tdm_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .master(master), .fmt(fmt),
    .slot_en(slot_en), .slot_dir(slot_dir), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .tx_wr(tx_wr), .tx_wr_slot(tx_wr_slot), .tx_wr_data(tx_wr_data),
    .rx_rd(rx_rd), .rx_rd_slot(rx_rd_slot), .rx_rd_data(rx_rd_data),
    .tx_dma_req(tx_dma_req), .tx_dma_clr(tx_dma_clr),
    .rx_dma_req(rx_dma_req), .rx_dma_clr(rx_dma_clr),
    .irq(irq), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .rxd(rxd),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .txd(txd), .txd_oe(txd_oe));

  wire lc  = master ? bclk_o : bclk_in;
  wire lfs = master ? fsync_o : fsync_in;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit txa(input int s);
    return slot_en[s] && (fmt != 2'd1 || slot_dir[s]);
  endfunction

  function automatic bit rxa(input int s);
    return slot_en[s] && (fmt != 2'd1 || !slot_dir[s]);
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge lc) begin
    int d;
    #0.5;
    if (run) begin
      if (!synced) begin
        if (lfs) begin synced = 1; p = 0; frame_no = 1; end
      end else begin
        p++;
        if (p == 96 * mult) begin p = 0; frame_no++; end
        if (master) chk(fsync_o == (p < mult), "R1 fsync pulse", fsync_o, int'(p < mult));
      end
      if (synced) begin
        if (p == 0 && frame_no >= 3)
          for (int s = 0; s < 12; s++)
            if (rxa(s)) begin
              rx_rd_slot = 4'(s);
              #0.1;
              chk(rx_rd_data == rxpat[s], "R3 R5 R6 rx byte", rx_rd_data, rxpat[s]);
            end
        d = p / mult;
        if (p % mult == 0) rxd = rxpat[d / 8][7 - (d % 8)];
      end
    end
  end

  always @(negedge lc) begin
    int d, s;
    #0.5;
    if (run && synced && (p % mult == mult - 1)) begin
      d = p / mult;
      s = d / 8;
      cap = {cap[6:0], txd};
      if (d % 8 == 7 && frame_no >= 2) begin
        chk(txd_oe == txa(s), "R4 R5 txd_oe per slot", txd_oe, txa(s));
        if (txa(s)) chk(cap == exp_tx[s], "R1 R3 R6 tx byte", cap, exp_tx[s]);
      end
    end
  end

  task automatic slave_period(input bit fs);
    fsync_in = fs;
    bclk_in = 1;
    wait_clks(H);
    bclk_in = 0;
    wait_clks(H);
  endtask

  task automatic run_test(input bit m, input logic [1:0] f, input bit mask);
    bit any_tx, any_rx;
    int edges;
    master = m; fmt = f; irq_mask = mask;
    slot_en  = 12'($urandom) | 12'h003;
    slot_dir = (12'($urandom) | 12'h001) & ~12'h002;
    mult = (f == 2'd2) ? 2 : 1;
    synced = 0; frame_no = 0; p = 0;
    any_tx = 0; any_rx = 0;
    for (int s = 0; s < 12; s++) begin
      exp_tx[s] = 8'($urandom);
      rxpat[s]  = 8'($urandom);
      any_tx |= txa(s);
      any_rx |= rxa(s);
      tx_wr = 1; tx_wr_slot = 4'(s); tx_wr_data = exp_tx[s];
      wait_clks(1);
    end
    tx_wr = 0;
    irq_clr = 1; tx_dma_clr = 1; rx_dma_clr = 1;
    wait_clks(1);
    irq_clr = 0; tx_dma_clr = 0; rx_dma_clr = 0;
    wait_clks(1);
    chk(tx_underrun == 0, "R9 no underrun before run", tx_underrun, 0);
    run = 1;
    if (m) begin
      edges = 0;
      for (int k = 0; k < 5 * HALF_EST; k++) begin
        if (bclk_o) edges++;
        wait_clks(1);
        if (k == 4 * HALF_EST - 1) break;
      end
      wait (frame_no >= 5);
      wait_clks(1);
    end else begin
      for (int k = 0; k < 5; k++) slave_period(0);
      for (int fr = 0; fr < 4; fr++)
        for (int q = 0; q < 96 * mult; q++) slave_period(q < mult);
      slave_period(1);
      fsync_in = 0;
    end
    run = 0;
    wait_clks(2);
    chk(bclk_o == 0 && fsync_o == 0 && txd_oe == 0, "R10 idle outputs", {bclk_o, fsync_o, txd_oe}, 0);
    chk(frame_no >= 5, "R1 frames counted", frame_no, 5);
    chk(irq == !mask, "R8 frame irq", irq, !mask);
    chk(tx_dma_req == any_tx, "R7 tx dma req", tx_dma_req, any_tx);
    chk(rx_dma_req == any_rx, "R7 rx dma req", rx_dma_req, any_rx);
    chk(tx_underrun == any_tx, "R9 underrun", tx_underrun, any_tx);
    chk(rx_overrun == any_rx, "R9 overrun", rx_overrun, any_rx);
    tx_dma_clr = 1;
    wait_clks(1);
    tx_dma_clr = 0;
    chk(tx_dma_req == 0 && rx_dma_req == any_rx, "R7 tx clear only", {tx_dma_req, rx_dma_req}, {1'b0, any_rx});
    rx_dma_clr = 1; irq_clr = 1;
    wait_clks(1);
    rx_dma_clr = 0; irq_clr = 0;
    chk(rx_dma_req == 0, "R7 rx clear", rx_dma_req, 0);
    chk(irq == 0 && tx_underrun == 0 && rx_overrun == 0, "R8 R9 clear", {irq, tx_underrun, rx_overrun}, 0);
  endtask

  localparam int HALF_EST = 4;

  task automatic check_divider;
    int lo, hi;
    master = 1; fmt = 0; run = 1;
    @(posedge bclk_o); #1;
    lo = 0; hi = 0;
    for (int k = 0; k < 8; k++) begin
      if (bclk_o) hi++; else lo++;
      wait_clks(1);
    end
    run = 0;
    wait_clks(2);
    chk(hi == 4 && lo == 4, "R2 bit clock half period", hi * 16 + lo, 8'h44);
    synced = 0; frame_no = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_clks(3);
    rst_n = 1;
    wait_clks(2);
    chk(bclk_o == 0 && fsync_o == 0 && txd_oe == 0, "R10 reset lines", {bclk_o, fsync_o, txd_oe}, 0);
    chk(irq == 0 && tx_dma_req == 0 && rx_dma_req == 0, "R7 R8 reset flags", {irq, tx_dma_req, rx_dma_req}, 0);
    check_divider();
    run_test(1, 2'd0, 0);
    run_test(1, 2'd1, 0);
    run_test(1, 2'd2, 1);
    run_test(0, 2'd0, 0);
    run_test(0, 2'd2, 1);
    run_test(0, 2'd1, 0);
    for (int t = 0; t < 2; t++) begin
      logic [1:0] f;
      f = 2'($urandom % 3);
      run_test(1'($urandom), f, 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule